// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Bit Shifter

This block moves up to eight bits at a time between an 8-bit data register and a serial EEPROM on a three-wire bus: a serial clock, a data line the block can drive or release, and a data input. A host loads the data register and then writes one control byte. The control byte sets the number of clocks, the direction, whether the data output is released after the last clock, and whether to wait for the memory's ready signal. The engine then produces the serial clocks from the system clock through a programmable divider and shifts bits out of the register's top or into its bottom.

A busy flag is held for the whole transfer. When the release and wait options are both set, the flag also covers the interval after the clocks stop, until the memory pulls the data line high to show that its internal programming cycle has finished. The cycle in which busy drops carries a one-cycle interrupt pulse. Command sequencing above the byte level is left to the host.

Top module: `eeprom3w_shifter`

## Requirements
- R1: The control byte is laid out as: bit 7 wait-for-ready, bit 5 release-after-last-clock, bit 4 read direction, bits 3:0 clock count. Counts above 8 are stored as 8. The status port returns these stored fields with busy in bit 6.
- R2: A control write accepted while idle raises busy in the next cycle. Control writes and data-register writes made while busy are ignored.
- R3: A transfer issues exactly min(count, 8) serial clock pulses. Each phase lasts HALF system cycles. The serial clock idles low and is never high while idle.
- R4: In write direction, bits leave MSB first. The bit on the data output is always the data register's MSB. The register shifts left by one, filling with 0, at the end of each high phase, so after n clocks it holds the old value shifted left by n.
- R5: In read direction, the synchronized data input is sampled at each rising serial clock edge and shifted into the register's LSB. After n clocks the register holds (old << n) | received bits, with the first received bit as the most significant of the n.
- R6: The data output enable is 0 after reset and is always 0 in read direction. In write direction with release set, it drops one system cycle after the last rising serial edge, and at once for a count of 0. With release clear, it stays 1.
- R7: With wait-for-ready and release both set, busy stays high after the clocks end until a rising edge is seen on the two-flop-synchronized data input. With release clear, the wait bit has no effect.
- R8: The interrupt output is high for exactly one cycle: the first cycle in which busy reads 0 after a transfer. There is exactly one pulse per accepted control write.
- R9: A count of 0 issues no clocks and, when not waiting for ready, holds busy for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | DATA_W | Data register write value |
| stat_rdata | output | 8 | Stored control fields with busy in bit 6 |
| dat_rdata | output | DATA_W | Data register contents |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | One-cycle pulse as busy falls |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data output value |
| sdo_oe | output | 1 | Serial data output enable |
| sdi | input | 1 | Serial data input |

## Verification
The hardest state to reach is the ready wait. It needs release and wait both set, the clocks already finished, and the data input going through a low-to-high change that the synchronizer sees only after the engine has entered its wait. The stimulus holds the input low for several cycles after the last clock, checks that busy is still high, and only then raises the line. The bench also issues control and data writes in the middle of a running transfer to confirm that neither the stored fields nor the shifted data change.

// File: rtl/eeprom3w_pkg.sv
package eeprom3w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOW  = 3'd1,
    ST_HIGH = 3'd2,
    ST_WAIT = 3'd3,
    ST_FIN  = 3'd4
  } xfer_state_e;

  localparam int CTL_WAIT_BIT = 7;
  localparam int CTL_BUSY_BIT = 6;
  localparam int CTL_REL_BIT  = 5;
  localparam int CTL_RD_BIT   = 4;
endpackage

// File: rtl/eeprom3w_sync.sv
module eeprom3w_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign dout = chain_q[STAGES-1];
  assign rise = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/eeprom3w_tick.sv
module eeprom3w_tick #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 2) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/eeprom3w_shifter.sv
module eeprom3w_shifter
  import eeprom3w_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HALF   = 4,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  input  logic              dat_wr,
  input  logic [DATA_W-1:0] dat_wdata,
  output logic [7:0]        stat_rdata,
  output logic [DATA_W-1:0] dat_rdata,
  output logic              busy,
  output logic              irq,
  output logic              sclk,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              sdi
);
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(DATA_W);

  xfer_state_e       state_q, state_n;
  logic              wait_q, rel_q, rd_q;
  logic [CNT_W-1:0]  cnt_q, left_q;
  logic [DATA_W-1:0] data_q;
  logic              busy_q, irq_q, sclk_q, drive_q;
  logic              sdi_s, sdi_rise, tick, run;
  logic              accept;
  logic [CNT_W-1:0]  cnt_in;

  eeprom3w_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(sdi), .dout(sdi_s), .rise(sdi_rise)
  );

  assign run = (state_q == ST_LOW) || (state_q == ST_HIGH);

  eeprom3w_tick #(.HALF(HALF)) u_tick (
    .clk(clk), .rst(rst), .run(run), .tick(tick)
  );

  assign accept = ctl_wr && !busy_q;
  assign cnt_in = (ctl_wdata[3:0] > MAX_CNT) ? MAX_CNT : ctl_wdata[3:0];

  always_comb begin
    state_n = state_q;
    case (state_q)
      ST_IDLE:
        if (accept) begin
          if (cnt_in != '0) state_n = ST_LOW;
          else if (ctl_wdata[CTL_WAIT_BIT] && ctl_wdata[CTL_REL_BIT]) state_n = ST_WAIT;
          else state_n = ST_FIN;
        end
      ST_LOW:  if (tick) state_n = ST_HIGH;
      ST_HIGH:
        if (tick) begin
          if (left_q == CNT_W'(1)) state_n = (wait_q && rel_q) ? ST_WAIT : ST_IDLE;
          else state_n = ST_LOW;
        end
      ST_WAIT: if (sdi_rise) state_n = ST_IDLE;
      ST_FIN:  state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
      irq_q   <= 1'b0;
      sclk_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      busy_q  <= (state_n != ST_IDLE);
      irq_q   <= busy_q && (state_n == ST_IDLE);
      sclk_q  <= (state_n == ST_HIGH);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q  <= 1'b0;
      rel_q   <= 1'b0;
      rd_q    <= 1'b0;
      cnt_q   <= '0;
      left_q  <= '0;
      drive_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (accept) begin
        wait_q  <= ctl_wdata[CTL_WAIT_BIT];
        rel_q   <= ctl_wdata[CTL_REL_BIT];
        rd_q    <= ctl_wdata[CTL_RD_BIT];
        cnt_q   <= cnt_in;
        left_q  <= cnt_in;
        drive_q <= !ctl_wdata[CTL_RD_BIT] && !(ctl_wdata[CTL_REL_BIT] && cnt_in == '0);
      end
      if (dat_wr && !busy_q) data_q <= dat_wdata;
      if (state_q == ST_LOW && tick && rd_q)
        data_q <= {data_q[DATA_W-2:0], sdi_s};
      if (state_q == ST_HIGH) begin
        if (left_q == CNT_W'(1) && rel_q) drive_q <= 1'b0;
        if (tick) begin
          left_q <= left_q - 1'b1;
          if (!rd_q) data_q <= {data_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign stat_rdata = {wait_q, busy_q, rel_q, rd_q, cnt_q};
  assign dat_rdata  = data_q;
  assign busy       = busy_q;
  assign irq        = irq_q;
  assign sclk       = sclk_q;
  assign sdo        = data_q[DATA_W-1];
  assign sdo_oe     = drive_q;

  assert_sclk_only_busy_R3: assert property (@(posedge clk) disable iff (rst)
    sclk_q |-> busy_q);
  assert_left_bounded_R3: assert property (@(posedge clk) disable iff (rst)
    left_q <= MAX_CNT);
  assert_no_drive_read_R6: assert property (@(posedge clk) disable iff (rst)
    (drive_q && busy_q) |-> !rd_q);
  assert_fields_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> ($stable(cnt_q) && $stable(rd_q) && $stable(rel_q) && $stable(wait_q)));
  assert_irq_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> irq_q);
  assert_irq_single_R8: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
  assert_wait_needs_rel_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT) |-> (wait_q && rel_q));
endmodule

// File: tb/eeprom3w_shifter_tb.sv
module eeprom3w_shifter_tb;
  localparam int HALF = 4;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_wr = 1'b0, dat_wr = 1'b0;
  logic [7:0] ctl_wdata = '0, dat_wdata = '0;
  logic [7:0] stat_rdata, dat_rdata;
  logic busy, irq, sclk, sdo, sdo_oe, sdi;

  always #2 clk = ~clk;

  eeprom3w_shifter #(.DATA_W(8), .HALF(HALF), .STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .stat_rdata(stat_rdata),
    .dat_rdata(dat_rdata), .busy(busy), .irq(irq), .sclk(sclk),
    .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
  );

  int checks = 0, fails = 0, cyc = 0;
  int pulses = 0, negs = 0, oe_bad = 0, irq_cnt = 0;
  logic [7:0] cap = '0;
  bit exp_rd = 0, man = 0, man_v = 0;
  int cur_n = 0, neg_base = 0;
  logic [7:0] cur_pat = '0;

  always @(posedge sclk) begin
    pulses <= pulses + 1;
    cap <= {cap[6:0], sdo};
    if (!exp_rd && !sdo_oe) oe_bad <= oe_bad + 1;
  end
  always @(negedge sclk) negs <= negs + 1;
  always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  always_comb begin
    int k;
    k = negs - neg_base;
    if (man) sdi = man_v;
    else if (cur_n == 0) sdi = 1'b0;
    else if (k < cur_n) sdi = cur_pat[cur_n-1-k];
    else sdi = cur_pat[0];
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == LIMIT) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog act=%0d exp=<%0d", cyc, LIMIT);
      summary();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit w, input bit h, input bit r, input logic [3:0] c,
                      input logic [7:0] d, input logic [7:0] pat, input bit poke);
    int n, pb, ob, ib;
    logic [7:0] expd;
    n = (c > 4'd8) ? 8 : int'(c);
    @(negedge clk);
    man = 0; cur_n = n; cur_pat = pat; neg_base = negs; exp_rd = r;
    pb = pulses; ob = oe_bad; ib = irq_cnt;
    dat_wr = 1; dat_wdata = d;
    @(negedge clk);
    dat_wr = 0;
    ctl_wr = 1; ctl_wdata = {w, 1'b0, h, r, c};
    @(negedge clk);
    ctl_wr = 0;
    chk("R2 busy after control write", busy, 1'b1);
    chk("R1 status fields", stat_rdata, {w, 1'b1, h, r, 4'(n)});
    if (n == 0 && !(w && h)) begin
      @(negedge clk);
      chk("R9 zero count busy one cycle", busy, 1'b0);
    end
    if (poke) begin
      @(negedge clk);
      ctl_wr = 1; ctl_wdata = ~{w, 1'b0, h, r, c} & 8'hBF;
      dat_wr = 1; dat_wdata = ~d;
      @(negedge clk);
      ctl_wr = 0; dat_wr = 0;
      chk("R2 control write ignored while busy", stat_rdata, {w, 1'b1, h, r, 4'(n)});
    end
    for (int t = 0; t < 400 && (pulses - pb) < n; t++) @(negedge clk);
    repeat (2*HALF + 4) @(negedge clk);
    if (w && h) begin
      chk("R7 busy held for ready", busy, 1'b1);
      man = 1; man_v = 0;
      repeat (5) @(negedge clk);
      chk("R7 still waiting with input low", busy, 1'b1);
      man_v = 1;
      repeat (6) @(negedge clk);
      chk("R7 busy released by rising input", busy, 1'b0);
    end else begin
      chk(w ? "R7 wait ignored without release" : "R3 busy ends after clocks", busy, 1'b0);
    end
    chk("R3 pulse count", pulses - pb, n);
    chk("R3 clock idles low", sclk, 1'b0);
    chk("R8 one interrupt per transfer", irq_cnt - ib, 1);
    chk("R6 output enable after transfer", sdo_oe, (!r && !h) ? 1'b1 : 1'b0);
    if (!r) begin
      chk("R6 output driven at every rising edge", oe_bad - ob, 0);
      if (n > 0) chk("R4 serial bits out MSB first", (cap & ((8'h1 << n) - 1)) & 8'hFF,
                     (n == 8) ? d : (d >> (8 - n)));
      expd = (n == 8) ? 8'h00 : 8'(d << n);
      chk("R4 register after write shift", dat_rdata, expd);
    end else begin
      expd = (n == 8) ? pat : 8'((d << n) | (pat & ((8'h1 << n) - 1)));
      chk("R5 register after read shift", dat_rdata, expd);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R3 reset busy", busy, 1'b0);
    chk("R8 reset irq", irq, 1'b0);
    chk("R3 reset sclk", sclk, 1'b0);
    chk("R6 reset output enable", sdo_oe, 1'b0);
    chk("R1 reset status", stat_rdata, 8'h00);
    xfer(0, 0, 0, 4'd8, 8'hA5, 8'h00, 0);
    xfer(0, 0, 1, 4'd8, 8'h00, 8'h3C, 0);
    xfer(0, 1, 0, 4'd0, 8'h81, 8'h00, 0);
    xfer(0, 0, 0, 4'd0, 8'h81, 8'h00, 0);
    xfer(0, 1, 0, 4'd12, 8'hC3, 8'h00, 0);
    xfer(0, 0, 1, 4'd1, 8'h55, 8'h01, 0);
    xfer(0, 0, 1, 4'd3, 8'h55, 8'h05, 0);
    xfer(1, 1, 0, 4'd8, 8'h96, 8'h00, 0);
    xfer(1, 0, 0, 4'd6, 8'hF0, 8'h00, 0);
    xfer(1, 1, 1, 4'd0, 8'h11, 8'h00, 0);
    xfer(0, 0, 0, 4'd7, 8'h6B, 8'h00, 1);
    xfer(0, 1, 1, 4'd5, 8'h6B, 8'h1A, 1);
    for (int i = 0; i < 40; i++) begin
      logic [7:0] rb;
      rb = 8'($urandom);
      xfer(rb[0], rb[1], rb[2], 4'($urandom % 16), 8'($urandom), 8'($urandom), rb[3]);
    end
    summary();
  end
endmodule